// File: doc/BRIEF.md
# Binary32 to 8-bit Float Narrowing Converter

This block takes one IEEE binary32 operand per cycle and turns it into an 8-bit floating-point code. A one-bit format select picks the target layout. Encoding 0 is a 5-bit-exponent, 2-bit-mantissa layout with infinity and NaN. Encoding 1 is a 4-bit-exponent, 3-bit-mantissa layout that saturates and has a single NaN code per sign. Rounding is always to nearest, with ties going to the even mantissa. The decision is made from a guard bit, a round bit and a sticky bit.

The conversion itself is combinational. One register stage holds the result together with a valid strobe. A result appears one clock after its operand is presented with `valid_i` high. While `valid_i` is low, the result register keeps its contents. Values too small for a normal target exponent come out as target subnormals. They are produced by shifting the significand further right before the rounding bits are taken, and values below half the smallest subnormal become a signed zero.

Top module: `fp32_to_fp8_cvt`

## Requirements
- R1: `valid_o` equals `valid_i` from the previous rising clock edge. While `rst_ni` is low, `valid_o` and `res_o` are both 0.
- R2: When `valid_i` is low at a clock edge, `res_o` keeps its previous value.
- R3: With `fmt_i`=0 the code is [7] sign, [6:2] exponent with bias 15, and [1:0] mantissa. With `fmt_i`=1 the code is [7] sign, [6:3] exponent with bias 7, and [2:0] mantissa. The output sign always equals `op_i[31]`.
- R4: A NaN operand (exponent field 255, mantissa nonzero) gives sign|0x7E with `fmt_i`=0 and sign|0x7F with `fmt_i`=1.
- R5: An infinite operand gives sign|0x7C with `fmt_i`=0 and sign|0x7E with `fmt_i`=1. The value 0x7E is the largest finite magnitude, 448.
- R6: An operand whose exponent and mantissa fields are both zero gives a zero with the operand's sign.
- R7: A finite result is the target value nearest the operand. When the operand lies exactly halfway between two target values, the one with an even mantissa (LSB 0) is chosen.
- R8: When the rebiased exponent (operand exponent − 127 + target bias) is below 1, the exponent field is 0 and the mantissa holds the subnormal value. Rounding follows R7, so binary32 subnormal operands and other tiny operands give a signed zero.
- R9: A round-up out of an all-ones mantissa clears the mantissa and increments the exponent field. This includes the step from the largest subnormal to the smallest normal.
- R10: A finite operand that rounds above the largest finite magnitude gives sign|0x7C (infinity) with `fmt_i`=0. With `fmt_i`=1 it gives sign|0x7E, so 0x7F/0xFF never results from a finite operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand strobe |
| fmt_i | input | 1 | Target format: 0 = 5-bit exponent, 1 = 4-bit exponent |
| op_i | input | 32 | Binary32 operand |
| valid_o | output | 1 | Result strobe, one cycle after `valid_i` |
| res_o | output | 8 | Converted 8-bit code |

## Verification
The sweep covers every binary32 exponent field in both signs and both formats. Each exponent is combined with mantissas that are zero, sticky-only, exactly half with an even kept LSB, exactly half with an odd kept LSB, just above half, just below half, all ones and a pseudo-random value. The two half-way patterns separate ties-to-even from round-half-up. The just-above and just-below patterns confirm that the sticky bit and the guard bit are weighed correctly. Because every exponent is covered, the sweep reaches the region where results become subnormal, where they underflow, where they carry into the next binade, and where they overflow in each format. Expected codes come from picking the nearest of all 8-bit target values in real arithmetic. Short runs with the strobe low check that the result holds.

// File: rtl/fp8_cvt_pkg.sv
package fp8_cvt_pkg;
  localparam int SRC_EXP_W = 8;
  localparam int SRC_MAN_W = 23;
  localparam int SRC_BIAS  = 127;
  localparam int SRC_SIG_W = SRC_MAN_W + 1;

  typedef enum logic {
    FMT_E5M2 = 1'b0,
    FMT_E4M3 = 1'b1
  } fp8_fmt_e;

  typedef struct packed {
    logic                 sign;
    logic                 is_nan;
    logic                 is_inf;
    logic                 is_zero;
    logic [SRC_EXP_W-1:0] exp;
    logic [SRC_SIG_W-1:0] sig;
  } src_unp_t;
endpackage

// File: rtl/fp32_classify.sv
module fp32_classify
  import fp8_cvt_pkg::*;
(
  input  logic [SRC_EXP_W+SRC_MAN_W:0] op_i,
  output src_unp_t                     unp_o
);
  logic [SRC_EXP_W-1:0] exp_f;
  logic [SRC_MAN_W-1:0] man_f;
  logic                 exp_ones, exp_zero, man_zero;

  assign exp_f    = op_i[SRC_EXP_W+SRC_MAN_W-1:SRC_MAN_W];
  assign man_f    = op_i[SRC_MAN_W-1:0];
  assign exp_ones = &exp_f;
  assign exp_zero = ~|exp_f;
  assign man_zero = ~|man_f;

  always_comb begin
    unp_o.sign    = op_i[SRC_EXP_W+SRC_MAN_W];
    unp_o.is_nan  = exp_ones & ~man_zero;
    unp_o.is_inf  = exp_ones & man_zero;
    unp_o.is_zero = exp_zero & man_zero;
    unp_o.exp     = exp_f;
    // hidden one only for a nonzero exponent field
    unp_o.sig     = {~exp_zero, man_f};
  end
endmodule

// File: rtl/fp8_narrow_core.sv
module fp8_narrow_core
  import fp8_cvt_pkg::*;
#(
  parameter int EXP_W   = 5,
  parameter int MAN_W   = 2,
  parameter bit HAS_INF = 1'b1
) (
  input  logic                   is_nan_i,
  input  logic                   is_inf_i,
  input  logic                   is_zero_i,
  input  logic [SRC_EXP_W-1:0]   exp_i,
  input  logic [SRC_SIG_W-1:0]   sig_i,
  output logic [EXP_W+MAN_W-1:0] mag_o
);
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int MAG_W   = EXP_W + MAN_W;
  localparam int RB_W    = SRC_EXP_W + 2;
  localparam int PAD_W   = 32;
  localparam int WIDE_W  = SRC_SIG_W + PAD_W;
  localparam int SH_CAP  = PAD_W;
  localparam int SH_W    = $clog2(SH_CAP + 1);
  localparam int SUM_W   = RB_W + MAN_W;
  localparam int EXP_ALL = (1 << EXP_W) - 1;
  localparam int G_POS   = WIDE_W - 2 - MAN_W;

  logic signed [RB_W-1:0] rb_exp;
  logic [RB_W-1:0]        sh_raw;
  logic                   sub;
  logic [SH_W-1:0]        sh;
  logic [WIDE_W-1:0]      wide;
  logic [MAN_W-1:0]       kept;
  logic                   guard, rnd, sticky, rnd_up;
  logic [RB_W-1:0]        exp_f;
  logic [SUM_W-1:0]       sum;
  logic [RB_W-1:0]        sum_exp;
  logic [MAN_W-1:0]       sum_man;
  logic                   ovf;
  logic [MAG_W-1:0]       nan_mag, inf_mag, ovf_mag;

  assign rb_exp = $signed({2'b00, exp_i}) - $signed(RB_W'(SRC_BIAS - BIAS));
  assign sub    = rb_exp < $signed(RB_W'(1));
  assign sh_raw = RB_W'(1) - RB_W'(rb_exp);
  assign sh     = !sub ? '0 :
                  (sh_raw > RB_W'(SH_CAP)) ? SH_W'(SH_CAP) : sh_raw[SH_W-1:0];

  // subnormal results: extra right shift before rounding bits are taken
  assign wide   = {sig_i, {PAD_W{1'b0}}} >> sh;
  assign kept   = wide[WIDE_W-2 -: MAN_W];
  assign guard  = wide[G_POS];
  assign rnd    = wide[G_POS-1];
  assign sticky = |wide[G_POS-2:0];
  assign rnd_up = guard & (rnd | sticky | kept[0]);

  // hidden bit still in place means a normal exponent
  assign exp_f  = wide[WIDE_W-1] ? RB_W'(rb_exp) : '0;
  assign sum    = {exp_f, kept} + SUM_W'(rnd_up);
  assign sum_exp = sum[SUM_W-1:MAN_W];
  assign sum_man = sum[MAN_W-1:0];

  generate
    if (HAS_INF) begin : g_ieee
      assign ovf     = sum_exp >= RB_W'(EXP_ALL);
      assign nan_mag = {EXP_W'(EXP_ALL), 1'b1, {(MAN_W-1){1'b0}}};
      assign inf_mag = {EXP_W'(EXP_ALL), {MAN_W{1'b0}}};
      assign ovf_mag = inf_mag;
    end else begin : g_sat
      assign ovf     = (sum_exp > RB_W'(EXP_ALL)) ||
                       ((sum_exp == RB_W'(EXP_ALL)) && (&sum_man));
      assign nan_mag = {MAG_W{1'b1}};
      assign inf_mag = {{(MAG_W-1){1'b1}}, 1'b0};
      assign ovf_mag = inf_mag;
    end
  endgenerate

  always_comb begin
    if (is_nan_i)       mag_o = nan_mag;
    else if (is_inf_i)  mag_o = inf_mag;
    else if (is_zero_i) mag_o = '0;
    else if (ovf)       mag_o = ovf_mag;
    else                mag_o = {sum_exp[EXP_W-1:0], sum_man};
  end
endmodule

// File: rtl/fp32_to_fp8_cvt.sv
module fp32_to_fp8_cvt
  import fp8_cvt_pkg::*;
#(
  parameter int A_EXP_W = 5,
  parameter int A_MAN_W = 2,
  parameter int B_EXP_W = 4,
  parameter int B_MAN_W = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         valid_i,
  input  logic                         fmt_i,
  input  logic [SRC_EXP_W+SRC_MAN_W:0] op_i,
  output logic                         valid_o,
  output logic [A_EXP_W+A_MAN_W:0]     res_o
);
  localparam int MAG_W = A_EXP_W + A_MAN_W;

  src_unp_t         unp;
  logic [MAG_W-1:0] mag_a, mag_b;
  logic [MAG_W:0]   res_d;

  fp32_classify u_cls (
    .op_i  (op_i),
    .unp_o (unp)
  );

  fp8_narrow_core #(.EXP_W(A_EXP_W), .MAN_W(A_MAN_W), .HAS_INF(1'b1)) u_core_a (
    .is_nan_i  (unp.is_nan),
    .is_inf_i  (unp.is_inf),
    .is_zero_i (unp.is_zero),
    .exp_i     (unp.exp),
    .sig_i     (unp.sig),
    .mag_o     (mag_a)
  );

  fp8_narrow_core #(.EXP_W(B_EXP_W), .MAN_W(B_MAN_W), .HAS_INF(1'b0)) u_core_b (
    .is_nan_i  (unp.is_nan),
    .is_inf_i  (unp.is_inf),
    .is_zero_i (unp.is_zero),
    .exp_i     (unp.exp),
    .sig_i     (unp.sig),
    .mag_o     (mag_b)
  );

  assign res_d = {unp.sign, (fmt_i == FMT_E4M3) ? mag_b : mag_a};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) res_o <= res_d;
    end
  end
endmodule

// File: rtl/fp8_cvt_checker.sv
module fp8_cvt_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic        fmt_i,
  input logic [31:0] op_i,
  input logic        valid_o,
  input logic [7:0]  res_o
);
  logic in_nan, in_inf;
  assign in_nan = (&op_i[30:23]) & (|op_i[22:0]);
  assign in_inf = (&op_i[30:23]) & ~(|op_i[22:0]);

  a_r1_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r1_valid_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o));
  a_r3_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> res_o[7] == $past(op_i[31]));
  a_r4_nan_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fmt_i && in_nan) |=> res_o[6:0] == 7'h7F);
  a_r5_inf_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !fmt_i && in_inf) |=> res_o[6:0] == 7'h7C);
  a_r10_no_nan_from_finite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fmt_i && !in_nan) |=> res_o[6:0] != 7'h7F);
endmodule

bind fp32_to_fp8_cvt fp8_cvt_checker u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .fmt_i   (fmt_i),
  .op_i    (op_i),
  .valid_o (valid_o),
  .res_o   (res_o)
);

// File: tb/fp32_to_fp8_cvt_bench.sv
`timescale 1ns/1ps
module fp32_to_fp8_cvt_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        fmt_i = 1'b0;
  logic [31:0] op_i = '0;
  logic        valid_o;
  logic [7:0]  res_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  fp32_to_fp8_cvt u_fp32_to_fp8_cvt (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .fmt_i(fmt_i),
    .op_i(op_i), .valid_o(valid_o), .res_o(res_o)
  );

  function automatic real code_val(input int c, input logic fmt);
    int mb = fmt ? 3 : 2;
    int bias = fmt ? 7 : 15;
    int ef = c >> mb;
    int mf = c & ((1 << mb) - 1);
    if (ef == 0) return real'(mf) * (2.0 ** (1 - bias - mb));
    return real'((1 << mb) + mf) * (2.0 ** (ef - bias - mb));
  endfunction

  function automatic real op_mag(input logic [31:0] op);
    int e = int'(op[30:23]);
    int m = int'(op[22:0]);
    if (e == 0) return real'(m) * (2.0 ** (-149));
    return real'((1 << 23) + m) * (2.0 ** (e - 150));
  endfunction

  // nearest target value, ties to the even code
  function automatic logic [7:0] ref_cvt(input logic [31:0] op, input logic fmt);
    logic s = op[31];
    int top = fmt ? 127 : 124;
    int best = 0;
    real x, d, bd;
    if ((&op[30:23]) && (|op[22:0])) return fmt ? {s, 7'h7F} : {s, 7'h7E};
    if (&op[30:23]) return fmt ? {s, 7'h7E} : {s, 7'h7C};
    x = op_mag(op);
    bd = x;
    for (int c = 1; c <= top; c++) begin
      d = x - code_val(c, fmt);
      if (d < 0.0) d = -d;
      if ((d < bd) || ((d == bd) && (c % 2 == 0))) begin
        best = c;
        bd = d;
      end
    end
    if (fmt && best == 127) best = 126;
    return {s, 7'(best)};
  endfunction

  function automatic string tag_of(input logic [31:0] op, input logic fmt, input logic [7:0] exp_c);
    int mb = fmt ? 3 : 2;
    int ef = int'(exp_c[6:0]) >> mb;
    int mf = int'(exp_c[6:0]) & ((1 << mb) - 1);
    if (&op[30:23]) return (|op[22:0]) ? "R4" : "R5";
    if (op[30:0] == 31'd0) return "R6";
    if ((!fmt && exp_c[6:0] == 7'h7C) || (fmt && exp_c[6:0] == 7'h7E && op_mag(op) > 448.0))
      return "R10";
    if (ef == 0) return "R8";
    if (mf == 0 && op_mag(op) < code_val(int'(exp_c[6:0]), fmt)) return "R9";
    return "R7";
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp_v);
    end
  endtask

  // drive at negedge, result registered at next posedge, sample at next negedge
  task automatic run(input logic [31:0] op, input logic fmt, input string req);
    logic [7:0] e;
    op_i = op; fmt_i = fmt; valid_i = 1'b1;
    @(negedge clk_i);
    e = ref_cvt(op, fmt);
    check(req.len() ? req : tag_of(op, fmt, e), res_o, e);
    check("R1", {7'd0, valid_o}, 8'd1);
  endtask

  initial begin
    logic [22:0] pats [8];
    logic [22:0] lfsr = 23'h5A3C1;
    logic [7:0]  held;
    repeat (3) @(negedge clk_i);
    check("R1", {7'd0, valid_o}, 8'd0);
    check("R1", res_o, 8'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    run(32'h3F800000, 1'b0, "R3"); check("R3", res_o, 8'h3C);
    run(32'h3F800000, 1'b1, "R3"); check("R3", res_o, 8'h38);
    run(32'hC0000000, 1'b0, "R3"); check("R3", res_o, 8'hC0);
    run(32'h3F900000, 1'b0, "R7"); check("R7", res_o, 8'h3C);
    run(32'h3FB00000, 1'b0, "R7"); check("R7", res_o, 8'h3E);
    run(32'h3FF00000, 1'b0, "R9"); check("R9", res_o, 8'h40);
    run(32'h43FA0000, 1'b1, "R10"); check("R10", res_o, 8'h7E);
    run(32'h47C35000, 1'b0, "R10"); check("R10", res_o, 8'h7C);
    run(32'h3B000000, 1'b1, "R8"); check("R8", res_o, 8'h01);
    run(32'hBA800000, 1'b1, "R8"); check("R8", res_o, 8'h80);
    run(32'hFFC00000, 1'b1, "R4"); check("R4", res_o, 8'hFF);
    run(32'h7F800000, 1'b1, "R5"); check("R5", res_o, 8'h7E);
    run(32'h80000000, 1'b0, "R6"); check("R6", res_o, 8'h80);

    // R2: strobe low, changing operand must not disturb the result
    held = res_o;
    valid_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      op_i = 32'h3F800000 + k; fmt_i = k[0];
      @(negedge clk_i);
      check("R2", res_o, held);
      check("R1", {7'd0, valid_o}, 8'd0);
    end

    for (int f = 0; f < 2; f++) begin
      int drop = f ? 20 : 21;
      for (int e = 0; e < 256; e++) begin
        lfsr = {lfsr[21:0], lfsr[22] ^ lfsr[17]};
        pats[0] = '0;
        pats[1] = 23'd1;
        pats[2] = 23'(1 << (drop - 1));
        pats[3] = 23'((1 << drop) | (1 << (drop - 1)));
        pats[4] = 23'((1 << (drop - 1)) | 1);
        pats[5] = 23'((1 << (drop - 1)) - 1);
        pats[6] = 23'h7FFFFF;
        pats[7] = lfsr;
        for (int p = 0; p < 8; p++)
          for (int s = 0; s < 2; s++)
            run({s[0], e[7:0], pats[p]}, f[0], "");
      end
    end

    valid_i = 1'b0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule